// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer for a small microcontroller. Software turns it on with an enable bit and picks a timeout period from eight power-of-two lengths. Once it is running, a tick counter advances on a prescaled clock. If software does not restart it in time, the block raises a reset request for exactly sixteen clock cycles. The timeout also sets a sticky overflow flag, so that boot code can tell that the last reset came from the watchdog.

A restart takes a two-byte key written to the restart register: 1Eh and then E1h. A single stray store cannot keep a runaway program alive, because a broken key has to be begun again. The timeout turns the watchdog off. Any reset from elsewhere in the chip also turns it off, so software must enable it again after every reset. The overflow flag survives every reset except power-on. Software clears it by writing zero to its bit.

Top module: `wdt_keyed`

## Requirements
- R1: After 1Eh and then E1h are written to the restart register (address 1), the timeout is counted again in full from the edge that captured the E1h write.
- R2: While enabled, the timeout occurs 2^(BASE_EXP+sel) prescaled ticks after enabling or restarting, which is 2^(BASE_EXP+sel)*PRESCALE clock cycles. The control register is address 0, with bit 0 as the enable and bits 3:1 as the period select `sel`.
- R3: A timeout drives `wdt_rst` high for exactly 16 consecutive clock cycles.
- R4: A timeout sets `ovf_flag`. The flag stays set through the pulse and through `sys_rst`. A control write with bit 7 = 0 clears it, a control write with bit 7 = 1 leaves it unchanged, and `por_n` low clears it.
- R5: When disabled, the block never times out. Writing the enable bit as 0 during a count cancels the pending timeout.
- R6: After power-on reset, after its own timeout and after `sys_rst`, the watchdog is disabled (`wdt_run` = 0) with select 0.
- R7: A restart-register write other than E1h that directly follows 1Eh abandons the key. The abandoning write does not arm a new key, even when it is 1Eh. E1h written without a preceding 1Eh is ignored. Control writes between the two key bytes do not disturb the key.
- R8: Register writes are ignored while `wdt_rst` is high.
- R9: `sys_rst` ends a running pulse at once and discards a half-entered key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst | input | 1 | Synchronous reset from other chip sources, active high; keeps the flag |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 restart |
| wr_data | input | 8 | Write data |
| wdt_rst | output | 1 | Reset request pulse of 16 cycles |
| ovf_flag | output | 1 | Sticky watchdog overflow flag |
| wdt_run | output | 1 | Watchdog currently enabled |

## Verification
The bench goes after the key sequence's corner cases. These are a repeated 1Eh (a design that re-arms on it would accept the restart that follows), a lone E1h, a control write between the two bytes, and a key cut off by `sys_rst`. In each case a wrong design shows up as a reset that arrives at the wrong cycle. It measures the timeout for every select value to the exact cycle, which catches off-by-one compare logic and a missing prescaler stage. It also counts the width of each pulse, which catches pulse counters that run 15 or 17 cycles. Writes issued during a pulse, and the flag's response to each reset source, expose a flag that clears too early or an enable that can be set while the reset request is high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    localparam logic [7:0] KEY_FIRST    = 8'h1E;
    localparam logic [7:0] KEY_SECOND   = 8'hE1;
    localparam int         PULSE_CYCLES = 16;
    localparam int         PULSE_W      = $clog2(PULSE_CYCLES + 1);
    localparam int         FLAG_BIT     = 7;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] DIV_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clr || !run)
            div_d = '0;
        else if (div_q == DIV_LAST)
            div_d = '0;
        else
            div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = run && (div_q == DIV_LAST);
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_clr,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       kick
);
    key_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        kick = 1'b0;
        if (sys_clr) begin
            st_d = KEY_IDLE;
        end else if (key_wr) begin
            case (st_q)
                KEY_IDLE:  if (key_data == KEY_FIRST) st_d = KEY_ARMED;
                KEY_ARMED: begin
                    st_d = KEY_IDLE;
                    kick = (key_data == KEY_SECOND);
                end
                default:   st_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    AST_KICK_IS_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        kick |-> key_wr) else $error("kick without write"); // R7
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3,
    parameter int PRESCALE = 12
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_clr,
    input  logic             run,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int NSEL = 1 << SEL_W;
    localparam int CW   = BASE_EXP + NSEL;

    logic          tick;
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_tab [NSEL];
    logic          at_last;

    wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .por_n(por_n),
        .clr  (kick || sys_clr),
        .run  (run),
        .tick (tick)
    );

    for (genvar g = 0; g < NSEL; g++) begin : g_last
        assign last_tab[g] = (CW'(1) << (BASE_EXP + g)) - CW'(1);
    end

    assign at_last = (cnt_q == last_tab[sel]);

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!run || sys_clr || kick) begin
            cnt_d = '0;
        end else if (tick) begin
            if (at_last) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_KICK_DEFERS: assert property (@(posedge clk) disable iff (!por_n)
        (kick && run) |=> !expire) else $error("expire right after kick"); // R1
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int BASE_EXP  = 14,
    parameter int SEL_W     = 3,
    parameter int PRESCALE  = 12,
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int KICK_ADDR = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wdt_rst,
    output logic              ovf_flag,
    output logic              wdt_run
);
    typedef struct packed {
        logic               en;
        logic [SEL_W-1:0]   sel;
        logic               ovf;
        logic [PULSE_W-1:0] pulse;
    } wdt_state_t;

    wdt_state_t st_d, st_q;
    logic       busy, ctrl_wr, key_wr, kick, expire;

    assign busy    = (st_q.pulse != '0);
    assign ctrl_wr = wr_en && !busy && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign key_wr  = wr_en && !busy && (wr_addr == ADDR_W'(KICK_ADDR));

    wdt_keyseq u_key (
        .clk     (clk),
        .por_n   (por_n),
        .sys_clr (sys_rst),
        .key_wr  (key_wr),
        .key_data(wr_data),
        .kick    (kick)
    );

    wdt_timer #(
        .BASE_EXP(BASE_EXP),
        .SEL_W   (SEL_W),
        .PRESCALE(PRESCALE)
    ) u_tmr (
        .clk    (clk),
        .por_n  (por_n),
        .sys_clr(sys_rst),
        .run    (st_q.en),
        .kick   (kick),
        .sel    (st_q.sel),
        .expire (expire)
    );

    always_comb begin
        st_d = st_q;
        if (busy) st_d.pulse = st_q.pulse - 1'b1;
        if (sys_rst) begin
            st_d.en    = 1'b0;
            st_d.sel   = '0;
            st_d.pulse = '0;
        end else if (expire) begin
            st_d.en    = 1'b0;
            st_d.sel   = '0;
            st_d.ovf   = 1'b1;
            st_d.pulse = PULSE_W'(PULSE_CYCLES);
        end else if (ctrl_wr) begin
            st_d.en  = wr_data[0];
            st_d.sel = wr_data[SEL_W:1];
            if (!wr_data[FLAG_BIT]) st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdt_rst  = busy;
    assign ovf_flag = st_q.ovf;
    assign wdt_run  = st_q.en;

    // checker: length of the current reset pulse
    logic [PULSE_W:0] hi_len_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       hi_len_q <= '0;
        else if (wdt_rst) hi_len_q <= hi_len_q + 1'b1;
        else              hi_len_q <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(wdt_rst) && !$past(sys_rst)) |-> (hi_len_q == (PULSE_W+1)'(PULSE_CYCLES)))
        else $error("pulse length wrong"); // R3
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!por_n)
        hi_len_q <= (PULSE_W+1)'(PULSE_CYCLES)) else $error("pulse too long"); // R3
    AST_FLAG_IN_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst |-> ovf_flag) else $error("flag low during pulse"); // R4
    AST_ONLY_WHEN_RUN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wdt_rst) |-> $past(wdt_run)) else $error("timeout while disabled"); // R5
    AST_OFF_AT_TIMEOUT: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst |-> !wdt_run) else $error("still enabled in pulse"); // R6
endmodule

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
    localparam int BASE = 4;
    localparam int PRE  = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdt_rst, ovf_flag, wdt_run;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int cap = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_keyed #(.BASE_EXP(BASE), .PRESCALE(PRE)) u0 (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .wdt_rst(wdt_rst), .ovf_flag(ovf_flag), .wdt_run(wdt_run)
    );

    function automatic int lim(input int sel);
        return (1 << (BASE + sel)) * PRE;
    endfunction

    function automatic bit key_step(inout bit armed, input logic [7:0] d);
        if (!armed) begin
            armed = (d == 8'h1E);
            return 1'b0;
        end
        armed = 1'b0;
        return d == 8'hE1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        cap = cyc;
    endtask

    task automatic enable(input int sel);
        wr(2'd0, 8'h81 | 8'(sel << 1));
    endtask

    task automatic wait_rise(output int rc);
        int n = 0;
        while (!wdt_rst && n < 20000) begin
            @(negedge clk);
            n++;
        end
        rc = cyc;
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (wdt_rst && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sys;
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
    endtask

    initial begin
        #(8ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rc, n, deadline;
        process::self().srandom(32'd1234);
        idle(3);
        chk(!wdt_rst && !ovf_flag && !wdt_run, "R6 reset state", {wdt_rst, ovf_flag, wdt_run}, 0);
        @(negedge clk); por_n = 1'b1;
        idle(2);

        // R5: disabled never times out
        wr(2'd0, 8'h80);
        idle(200);
        chk(!wdt_rst && !ovf_flag, "R5 disabled idle", wdt_rst, 0);

        // R2/R3/R4/R6: every select value
        for (int s = 0; s < 8; s++) begin
            enable(s);
            chk(wdt_run == 1'b1, "R2 enabled", wdt_run, 1);
            wait_rise(rc);
            chk(rc - cap == lim(s), "R2 timeout period", rc - cap, lim(s));
            chk(ovf_flag && !wdt_run, "R4 flag set / R6 disabled", {ovf_flag, wdt_run}, 2);
            pulse_len(n);
            chk(n == 16, "R3 pulse length", n, 16);
            chk(ovf_flag, "R4 flag sticky after pulse", ovf_flag, 1);
            wr(2'd0, 8'h80);
            chk(ovf_flag, "R4 bit7=1 keeps flag", ovf_flag, 1);
            wr(2'd0, 8'h00);
            chk(!ovf_flag, "R4 bit7=0 clears flag", ovf_flag, 0);
        end

        // R1: repeated restarts keep it alive, then exact timeout
        enable(1);
        for (int k = 0; k < 10; k++) begin
            idle(40);
            wr(2'd1, 8'h1E);
            wr(2'd1, 8'hE1);
            chk(!wdt_rst, "R1 restart keeps alive", wdt_rst, 0);
        end
        wait_rise(rc);
        chk(rc - cap == lim(1), "R1 timeout after restart", rc - cap, lim(1));
        idle(20);

        // R7: abandoned keys do not restart
        enable(1); deadline = cap + lim(1);
        wr(2'd1, 8'h1E); wr(2'd1, 8'h55); wr(2'd1, 8'hE1);
        wr(2'd1, 8'h1E); wr(2'd1, 8'h1E); wr(2'd1, 8'hE1);
        wr(2'd1, 8'hE1);
        wait_rise(rc);
        chk(rc == deadline, "R7 abandoned key ignored", rc - deadline, 0);
        // R8: writes during pulse ignored
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h1E);
        idle(20);
        chk(!wdt_run && ovf_flag, "R8 writes ignored in pulse", {wdt_run, ovf_flag}, 1);
        wr(2'd1, 8'hE1);
        enable(0); deadline = cap + lim(0);
        idle(5);
        wr(2'd1, 8'hE1);
        wait_rise(rc);
        chk(rc == deadline, "R8 key not armed during pulse", rc - deadline, 0);
        idle(20);

        // R7: control write between key bytes does not disturb
        enable(1);
        wr(2'd1, 8'h1E); wr(2'd0, 8'h83); wr(2'd1, 8'hE1);
        deadline = cap + lim(1);
        wait_rise(rc);
        chk(rc == deadline, "R7 ctrl write between bytes", rc - deadline, 0);

        // R9: sys_rst ends pulse, keeps flag
        idle(4);
        pulse_sys;
        chk(!wdt_rst && ovf_flag && !wdt_run, "R9 sys_rst ends pulse", {wdt_rst, ovf_flag, wdt_run}, 2);
        // R9: sys_rst discards a half key
        enable(2);
        wr(2'd1, 8'h1E);
        pulse_sys;
        chk(!wdt_run, "R6 sys_rst disables", wdt_run, 0);
        enable(0); deadline = cap + lim(0);
        wr(2'd1, 8'hE1);
        wait_rise(rc);
        chk(rc == deadline, "R9 half key discarded", rc - deadline, 0);
        idle(20);

        // R5: disable mid-count cancels timeout
        enable(0);
        idle(10);
        wr(2'd0, 8'h80);
        idle(100);
        chk(!wdt_rst, "R5 disable cancels timeout", wdt_rst, 0);

        // R4: por_n clears flag
        chk(ovf_flag, "R4 flag before por", ovf_flag, 1);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk(!ovf_flag && !wdt_run, "R4 por clears flag", ovf_flag, 0);

        // Random key traffic against a model
        for (int r = 0; r < 8; r++) begin
            int s, gap, pick;
            bit armed;
            logic [7:0] d;
            s = $urandom_range(0, 2);
            armed = 1'b0;
            enable(s); deadline = cap + lim(s);
            for (int i = 0; i < 40; i++) begin
                gap = $urandom_range(0, 3);
                if (cyc + gap + 3 > deadline) break;
                idle(gap);
                pick = $urandom_range(0, 3);
                d = (pick == 0) ? 8'h1E : (pick == 1) ? 8'hE1 :
                    (pick == 2) ? 8'h1E : 8'($urandom);
                wr(2'd1, d);
                if (key_step(armed, d)) deadline = cap + lim(s);
                chk(!wdt_rst, "R7 random no early reset", wdt_rst, 0);
            end
            wait_rise(rc);
            chk(rc == deadline, "R1 R7 random timeout", rc - deadline, 0);
            pulse_len(n);
            chk(n == 16, "R3 random pulse", n, 16);
            wr(2'd0, 8'h00);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule